// File: doc/BRIEF.md
# Dual-Channel Sample Demultiplexer with Forwarded Data Clock

This block sits behind a pair of 8-bit converter cores, I and Q. Each core delivers one code per input clock. The block places these codes on a parallel output bus and forwards a data clock that a receiver uses to latch the bus.

In demultiplexed mode, every channel owns two ports. The delayed port carries the earlier of two consecutive samples and the direct port carries the later one. Both ports change together, so the word rate is half the sample rate. In single-port mode, only the direct ports carry data, one sample per input clock, and the delayed ports are driven low with their output enable deasserted.

The forwarded clock runs at one of three rates:
- half the input rate for demultiplexed single-edge timing;
- a quarter of the input rate for demultiplexed double-edge timing;
- half the input rate in single-port mode, which always uses double-edge timing.

An edge-select input sets where the clock edges fall relative to data changes. A mirror output copies the clock exactly.

A realign pulse, synchronized into the input clock domain, holds the clock low and restarts its phase, so several devices can be brought into step. A trim-gate input stops the clock while the converters trim their terminations, unless a trim-bypass input is set. Over-range and under-range flags from the cores force the codes to full scale or zero and raise an out-of-range output.

Top module: `ddm_top`

## Requirements
- R1: In demultiplexed mode (`demux_en`=1), samples are numbered by the edge that captures them, where edge E0 is the first edge at which the realign phase restarts. Samples captured at edges E(2k) and E(2k+1) appear together after edge E(2k+2): the earlier sample on the delayed port and the later sample on the direct port, for both channels.
- R2: In demultiplexed mode with `ddr_en`=0, the clock is high after edge Ej exactly when j is even if `edge_sel`=0, and exactly when j is odd if `edge_sel`=1. The clock period is therefore 2 input clocks, rising with each word change for `edge_sel`=0 and falling with it for `edge_sel`=1.
- R3: In demultiplexed mode with `ddr_en`=1, the clock period is 4 input clocks. With `edge_sel`=0 it is high after Ej when j mod 4 is 0 or 1, so each edge coincides with a word change. With `edge_sel`=1 it is high when j mod 4 is 1 or 2, so each edge falls midway between word changes.
- R4: In single-port mode (`demux_en`=0), the sample captured at E(j-1) appears on the direct ports after Ej. The delayed ports read 0 and `delayed_oe` is 0. The clock is high after Ej exactly when j is even, and neither `ddr_en` nor `edge_sel` has any effect.
- R5: Consider a realign pulse `sync_pulse` seen high at edges a through b-1 and low from edge b onward. The clock is low after edges a+2 through b+1, and edge b+2 is E0.
- R6: `dclk_mirror` equals `dclk` in every cycle.
- R7: While `trim_active`=1 and `trim_bypass`=0 are seen at an edge, both clock outputs are low after that edge, and the data ports keep updating on schedule. With `trim_bypass`=1, `trim_active` has no effect on the clock.
- R8: A sample flagged over range is output as 255, and a sample flagged under range is output as 0. The over-range flag wins when both flags are set. Otherwise the raw code passes unchanged.
- R9: `out_of_range` changes together with the data ports. It is the OR of both range flags of every sample currently shown: four samples in demultiplexed mode, two in single-port mode.
- R10: While `rst_n` is low, every output is 0.
- R11: The data ports and `out_of_range` change only at word-load edges, which occur at every second edge in demultiplexed mode. All four ports update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_code | input | 8 | I-channel raw code |
| i_over | input | 1 | I-channel above full scale |
| i_under | input | 1 | I-channel below full scale |
| q_code | input | 8 | Q-channel raw code |
| q_over | input | 1 | Q-channel above full scale |
| q_under | input | 1 | Q-channel below full scale |
| demux_en | input | 1 | 1: two ports per channel; 0: single port |
| ddr_en | input | 1 | Double-edge clocking in demultiplexed mode |
| edge_sel | input | 1 | Clock edge placement relative to data |
| sync_pulse | input | 1 | Realign pulse, asynchronous |
| trim_active | input | 1 | Termination trim in progress |
| trim_bypass | input | 1 | Keeps the clock running during trim |
| i_direct | output | 8 | I-channel later sample |
| i_delayed | output | 8 | I-channel earlier sample |
| q_direct | output | 8 | Q-channel later sample |
| q_delayed | output | 8 | Q-channel earlier sample |
| delayed_oe | output | 1 | Output enable for the delayed ports |
| dclk | output | 1 | Forwarded data clock |
| dclk_mirror | output | 1 | Copy of the data clock |
| out_of_range | output | 1 | Range flag for the shown words |

## Verification
A trim gate and a word load can fall on the same edge. The trim stimulus is raised so that it covers an even edge, where a word is loaded. The bench then checks that the clock is low while the new pair still appears with the correct codes and flag.

A realign can also land while a pair is half captured. This is provoked by issuing realign pulses from whatever phase the previous test left behind. The bench judges it by requiring the clock to stay low through the hold and the first pair after E0 to follow R1 exactly.

// File: rtl/ddm_pkg.sv
package ddm_pkg;

  localparam int PH_W = 2;

  typedef enum logic [1:0] {
    CK_SDR_HALF    = 2'd0,
    CK_DDR_QUARTER = 2'd1,
    CK_DDR_HALF    = 2'd2
  } ck_mode_e;

  function automatic ck_mode_e pick_mode(input logic demux, input logic ddr);
    if (!demux)   return CK_DDR_HALF;
    else if (ddr) return CK_DDR_QUARTER;
    else          return CK_SDR_HALF;
  endfunction

  // clock level to present after an edge taken at phase p
  function automatic logic dclk_level(input ck_mode_e m, input logic es,
                                      input logic [PH_W-1:0] p);
    logic lv;
    case (m)
      CK_SDR_HALF:    lv = es ? p[0] : ~p[0];
      CK_DDR_QUARTER: lv = es ? (p[0] ^ p[1]) : ~p[1];
      default:        lv = ~p[0];
    endcase
    return lv;
  endfunction

  // word load happens at an edge taken at phase p
  function automatic logic word_load(input ck_mode_e m, input logic [PH_W-1:0] p);
    logic ld;
    case (m)
      CK_DDR_HALF: ld = 1'b1;
      default:     ld = ~p[0];
    endcase
    return ld;
  endfunction

endpackage

// File: rtl/ddm_sample.sv
module ddm_sample #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] raw,
  input  logic          over,
  input  logic          under,
  output logic [DW-1:0] cur,
  output logic [DW-1:0] prv,
  output logic          cur_f,
  output logic          prv_f
);

  logic [DW-1:0] cur_d, prv_d;
  logic          cur_f_d, prv_f_d;

  always_comb begin
    if (over)       cur_d = {DW{1'b1}};
    else if (under) cur_d = '0;
    else            cur_d = raw;
    cur_f_d = over | under;
    prv_d   = cur;
    prv_f_d = cur_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      prv   <= '0;
      cur_f <= 1'b0;
      prv_f <= 1'b0;
    end else begin
      cur   <= cur_d;
      prv   <= prv_d;
      cur_f <= cur_f_d;
      prv_f <= prv_f_d;
    end
  end

  // R8: clamp to full scale / zero
  p_clamp_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> (cur == {DW{1'b1}}));
  p_clamp_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !over) |=> (cur == '0));

endmodule

// File: rtl/ddm_phase.sv
module ddm_phase
  import ddm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_pulse,
  input  logic demux_en,
  input  logic ddr_en,
  input  logic edge_sel,
  input  logic trim_active,
  input  logic trim_bypass,
  output logic load,
  output logic dclk,
  output logic dclk_mirror
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [PH_W-1:0]        ph_q, ph_d;
  logic                   hold, gate, dclk_d;
  ck_mode_e               mode;

  assign hold = sync_q[SYNC_STAGES-1];
  assign gate = trim_active & ~trim_bypass;
  assign mode = pick_mode(demux_en, ddr_en);

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], sync_pulse};
    ph_d   = hold ? '0 : ph_q + PH_W'(1);
    load   = ~hold & word_load(mode, ph_q);
    dclk_d = (hold | gate) ? 1'b0 : dclk_level(mode, edge_sel, ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= '0;
      ph_q        <= '0;
      dclk        <= 1'b0;
      dclk_mirror <= 1'b0;
    end else begin
      sync_q      <= sync_d;
      ph_q        <= ph_d;
      dclk        <= dclk_d;
      dclk_mirror <= dclk_d;
    end
  end

  // checker aid: previous edge was an ungated single-edge demux edge
  logic run_sdr, run_q;
  assign run_sdr = (mode == CK_SDR_HALF) & ~hold & ~gate;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_sdr;
  end

  p_hold_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (ph_q == '0 && !dclk && !dclk_mirror));
  p_trim_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> (!dclk && !dclk_mirror));
  p_sdr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_sdr && run_q && $stable(edge_sel)) |=> (dclk != $past(dclk)));

endmodule

// File: rtl/ddm_words.sv
module ddm_words #(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    demux_en,
  input  logic [NCH-1:0][DW-1:0]  cur,
  input  logic [NCH-1:0][DW-1:0]  prv,
  input  logic [NCH-1:0]          cur_f,
  input  logic [NCH-1:0]          prv_f,
  output logic [NCH-1:0][DW-1:0]  direct,
  output logic [NCH-1:0][DW-1:0]  delayed,
  output logic                    delayed_oe,
  output logic                    oor
);

  logic [NCH-1:0][DW-1:0] direct_d, delayed_d;
  logic                   oe_d, oor_d;

  always_comb begin
    direct_d  = direct;
    delayed_d = delayed;
    oe_d      = delayed_oe;
    oor_d     = oor;
    if (load) begin
      direct_d  = cur;
      delayed_d = demux_en ? prv : '0;
      oe_d      = demux_en;
      oor_d     = (|cur_f) | (demux_en & (|prv_f));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      direct     <= '0;
      delayed    <= '0;
      delayed_oe <= 1'b0;
      oor        <= 1'b0;
    end else begin
      direct     <= direct_d;
      delayed    <= delayed_d;
      delayed_oe <= oe_d;
      oor        <= oor_d;
    end
  end

  p_words_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({direct, delayed, oor}));
  p_delayed_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !demux_en) |=> (!delayed_oe && delayed == '0));

endmodule

// File: rtl/ddm_top.sv
module ddm_top #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] i_code,
  input  logic          i_over,
  input  logic          i_under,
  input  logic [DW-1:0] q_code,
  input  logic          q_over,
  input  logic          q_under,
  input  logic          demux_en,
  input  logic          ddr_en,
  input  logic          edge_sel,
  input  logic          sync_pulse,
  input  logic          trim_active,
  input  logic          trim_bypass,
  output logic [DW-1:0] i_direct,
  output logic [DW-1:0] i_delayed,
  output logic [DW-1:0] q_direct,
  output logic [DW-1:0] q_delayed,
  output logic          delayed_oe,
  output logic          dclk,
  output logic          dclk_mirror,
  output logic          out_of_range
);

  localparam int NCH = 2;

  logic [NCH-1:0][DW-1:0] raw, cur, prv, direct, delayed;
  logic [NCH-1:0]         over, under, cur_f, prv_f;
  logic                   load;

  assign raw   = {q_code, i_code};
  assign over  = {q_over, i_over};
  assign under = {q_under, i_under};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ddm_sample #(.DW(DW)) u_sample (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw[c]),
      .over  (over[c]),
      .under (under[c]),
      .cur   (cur[c]),
      .prv   (prv[c]),
      .cur_f (cur_f[c]),
      .prv_f (prv_f[c])
    );
  end

  ddm_phase #(.SYNC_STAGES(SYNC_STAGES)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_pulse  (sync_pulse),
    .demux_en    (demux_en),
    .ddr_en      (ddr_en),
    .edge_sel    (edge_sel),
    .trim_active (trim_active),
    .trim_bypass (trim_bypass),
    .load        (load),
    .dclk        (dclk),
    .dclk_mirror (dclk_mirror)
  );

  ddm_words #(.DW(DW), .NCH(NCH)) u_words (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .demux_en   (demux_en),
    .cur        (cur),
    .prv        (prv),
    .cur_f      (cur_f),
    .prv_f      (prv_f),
    .direct     (direct),
    .delayed    (delayed),
    .delayed_oe (delayed_oe),
    .oor        (out_of_range)
  );

  assign i_direct  = direct[0];
  assign q_direct  = direct[1];
  assign i_delayed = delayed[0];
  assign q_delayed = delayed[1];

  // R6: mirror clock tracks the main clock
  p_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_mirror == dclk);

endmodule

// File: tb/ddm_top_bench.sv
`timescale 1ns/1ps
module ddm_top_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] i_code, q_code;
  logic       i_over, i_under, q_over, q_under;
  logic       demux_en, ddr_en, edge_sel, sync_pulse, trim_active, trim_bypass;
  logic [7:0] i_direct, i_delayed, q_direct, q_delayed;
  logic       delayed_oe, dclk, dclk_mirror, out_of_range;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ddm_top u_ddm_top (
    .clk(clk), .rst_n(rst_n),
    .i_code(i_code), .i_over(i_over), .i_under(i_under),
    .q_code(q_code), .q_over(q_over), .q_under(q_under),
    .demux_en(demux_en), .ddr_en(ddr_en), .edge_sel(edge_sel),
    .sync_pulse(sync_pulse), .trim_active(trim_active), .trim_bypass(trim_bypass),
    .i_direct(i_direct), .i_delayed(i_delayed),
    .q_direct(q_direct), .q_delayed(q_delayed),
    .delayed_oe(delayed_oe), .dclk(dclk), .dclk_mirror(dclk_mirror),
    .out_of_range(out_of_range)
  );

  // {i[35:28], i_over[27], i_under[26], q[25:18], q_over[17], q_under[16], exp_i[15:8], exp_q[7:0]}
  localparam logic [35:0] VEC [0:7] = '{
    {8'd10,  1'b0, 1'b0, 8'd20,  1'b0, 1'b0, 8'd10,  8'd20},
    {8'd33,  1'b0, 1'b0, 8'd44,  1'b0, 1'b0, 8'd33,  8'd44},
    {8'd5,   1'b1, 1'b0, 8'd77,  1'b0, 1'b0, 8'd255, 8'd77},
    {8'd200, 1'b0, 1'b0, 8'd9,   1'b0, 1'b1, 8'd200, 8'd0},
    {8'd128, 1'b1, 1'b1, 8'd1,   1'b0, 1'b0, 8'd255, 8'd1},
    {8'hFF,  1'b0, 1'b0, 8'h00,  1'b0, 1'b0, 8'hFF,  8'h00},
    {8'h55,  1'b0, 1'b0, 8'hAA,  1'b0, 1'b0, 8'h55,  8'hAA},
    {8'h0F,  1'b0, 1'b0, 8'hF0,  1'b0, 1'b0, 8'h0F,  8'hF0}
  };

  function automatic int e_i(input int k);   return 32'(VEC[k][15:8]); endfunction
  function automatic int e_q(input int k);   return 32'(VEC[k][7:0]);  endfunction
  function automatic int e_f(input int k);
    return (VEC[k][27] | VEC[k][26] | VEC[k][17] | VEC[k][16]) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int k);
    if (k >= 0 && k < 8) begin
      i_code = VEC[k][35:28]; i_over = VEC[k][27]; i_under = VEC[k][26];
      q_code = VEC[k][25:18]; q_over = VEC[k][17]; q_under = VEC[k][16];
    end else begin
      i_code = 8'd0; i_over = 1'b0; i_under = 1'b0;
      q_code = 8'd0; q_over = 1'b0; q_under = 1'b0;
    end
  endtask

  // leaves the bench at a negedge; the next rising edge is E0
  task automatic realign();
    sync_pulse = 1'b1;
    tick(); tick(); tick();
    chk("R5 clock held low", 32'(dclk), 0);
    sync_pulse = 1'b0;
    tick();
    chk("R5 clock held low", 32'(dclk), 0);
    tick();
    chk("R5 clock held low", 32'(dclk), 0);
    chk("R6 mirror", 32'(dclk_mirror), 0);
  endtask

  task automatic check_pair(input int k, input string tag);
    chk({tag, " R1 i delayed"}, 32'(i_delayed), e_i(2*k));
    chk({tag, " R1 i direct"},  32'(i_direct),  e_i(2*k+1));
    chk({tag, " R1 q delayed"}, 32'(q_delayed), e_q(2*k));
    chk({tag, " R1 q direct"},  32'(q_direct),  e_q(2*k+1));
    chk({tag, " R9 oor"}, 32'(out_of_range), e_f(2*k) | e_f(2*k+1));
    chk({tag, " R1 oe"}, 32'(delayed_oe), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    demux_en = 1'b1; ddr_en = 1'b0; edge_sel = 1'b0;
    sync_pulse = 1'b0; trim_active = 1'b0; trim_bypass = 1'b0;
    drive(-1);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 dclk", 32'(dclk), 0);
    chk("R10 mirror", 32'(dclk_mirror), 0);
    chk("R10 words", 32'({i_direct, i_delayed, q_direct, q_delayed}), 0);
    chk("R10 oe/oor", 32'({delayed_oe, out_of_range}), 0);
    rst_n = 1'b1;
    tick();

    // table walk: demux, single-edge clock, edge_sel=0
    realign();
    for (int j = 0; j < 10; j++) begin
      drive(j);
      tick();
      chk("R2 sdr clock", 32'(dclk), (j % 2 == 0) ? 1 : 0);
      chk("R6 mirror", 32'(dclk_mirror), 32'(dclk));
      if (j >= 2 && j % 2 == 0) check_pair(j/2 - 1, "sdr");
      if (j >= 3 && j % 2 == 1) begin
        chk("R11 i direct stable", 32'(i_direct), e_i(j-2));
        chk("R11 q delayed stable", 32'(q_delayed), e_q(j-3));
      end
    end

    // edge_sel=1, single-edge
    edge_sel = 1'b1;
    drive(-1);
    realign();
    for (int j = 0; j < 6; j++) begin
      tick();
      chk("R2 sdr clock edge_sel=1", 32'(dclk), (j % 2 == 1) ? 1 : 0);
    end

    // double-edge demux, edge_sel=0
    ddr_en = 1'b1; edge_sel = 1'b0;
    realign();
    for (int j = 0; j < 10; j++) begin
      drive(j);
      tick();
      chk("R3 ddr clock", 32'(dclk), (j % 4 < 2) ? 1 : 0);
      if (j >= 2 && j % 2 == 0) check_pair(j/2 - 1, "ddr");
    end

    // double-edge demux, edge_sel=1
    edge_sel = 1'b1;
    drive(-1);
    realign();
    for (int j = 0; j < 8; j++) begin
      tick();
      chk("R3 ddr clock edge_sel=1", 32'(dclk), (j % 4 == 1 || j % 4 == 2) ? 1 : 0);
    end

    // single-port mode; ddr_en=0 and edge_sel=1 must have no effect
    demux_en = 1'b0; ddr_en = 1'b0; edge_sel = 1'b1;
    realign();
    for (int j = 0; j < 9; j++) begin
      drive(j);
      tick();
      chk("R4 single-port clock", 32'(dclk), (j % 2 == 0) ? 1 : 0);
      if (j >= 1) begin
        chk("R4 i direct", 32'(i_direct), e_i(j-1));
        chk("R4 q direct", 32'(q_direct), e_q(j-1));
        chk("R4 delayed zero", 32'({i_delayed, q_delayed}), 0);
        chk("R4 oe low", 32'(delayed_oe), 0);
        chk("R9 single oor", 32'(out_of_range), e_f(j-1));
      end
    end

    // trim gate falling on load edges, then bypass
    demux_en = 1'b1; ddr_en = 1'b0; edge_sel = 1'b0;
    realign();
    for (int j = 0; j < 10; j++) begin
      drive(j);
      trim_active = (j >= 2 && j <= 7) ? 1'b1 : 1'b0;
      trim_bypass = (j >= 5) ? 1'b1 : 1'b0;
      tick();
      if (j >= 2 && j <= 4)
        chk("R7 trim gate low", 32'(dclk), 0);
      else
        chk("R7 clock with bypass/no trim", 32'(dclk), (j % 2 == 0) ? 1 : 0);
      chk("R6 mirror", 32'(dclk_mirror), 32'(dclk));
      if (j >= 2 && j % 2 == 0) check_pair(j/2 - 1, "trim");
    end
    trim_active = 1'b0; trim_bypass = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule